// File: doc/BRIEF.md
# Multi-Channel DMA Interrupt Aggregator

This block gathers interrupt causes from up to 64 DMA channels and folds them onto a small set of interrupt lines, four by default. Every channel keeps its own copy of a status word and a mask word for each line. Each status word holds two latched causes: a completion cause and a fault cause. A one-cycle pulse on a channel's completion or fault input sets that cause in every line's copy. Software then clears each copy on its own by writing ones. Even channels carry outbound traffic and odd channels carry inbound traffic. For each line there are two summary words, one per direction, with one bit per channel pair. A per-line global status word collects chip-level event pulses and is also cleared by writing ones.

A narrow register port selects a register kind, a channel and a line. A write either clears causes, loads a mask or clears global bits. A read returns the selected word one cycle later. Each interrupt line is a register. It is high when any masked cause in its outbound summary, its inbound summary or its global status is set.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After a synchronous reset, every status copy, every mask and every global status bit is zero, `irq_o` is zero and `reg_rdata_o` is zero.
- R2: A pulse on `done_pulse_i[c]` sets bit 0 of channel c's status word in every line's copy. A pulse on `err_pulse_i[c]` sets bit 6 in every copy. The status word is read with `reg_kind_i` = 0, and all its other bits read as zero.
- R3: A write with `reg_kind_i` = 0 clears the status bits (bit 0, bit 6) that are 1 in `reg_wdata_i`. It acts only on the selected channel and line. Bits written as 0, other lines and other channels keep their values.
- R4: When a cause pulse and a clear of the same status bit fall in the same cycle, the bit ends up set. The same applies to a global status bit whose pulse and clear coincide.
- R5: A write with `reg_kind_i` = 1 loads the selected channel and line's mask from `reg_wdata_i` bit 0 (completion enable) and bit 6 (fault enable). A read of that kind returns those two bits, and every other bit reads as zero.
- R6: Reading `reg_kind_i` = 2 returns the outbound summary of line `reg_out_i`. Bit p is set when even channel 2p has (status bit 0 AND mask bit 0) OR (status bit 6 AND mask bit 6) for that line. Reading `reg_kind_i` = 3 returns the inbound summary, built the same way from odd channel 2p+1.
- R7: A pulse on `glb_pulse_i[g]` sets global bit g of every line. A write with `reg_kind_i` = 4 clears the selected line's global bits that are 1 in `reg_wdata_i`. A read of that kind returns the line's global bits in the low bits.
- R8: `irq_o[o]` is set one cycle after line o has a nonzero outbound summary, inbound summary or global status. A cause whose mask bit is 0 never raises it.
- R9: Writes with `reg_kind_i` = 2, 3 or 5..7 change no status, mask or global bit.
- R10: `reg_rdata_o` is loaded on the clock edge that samples `reg_re_i` high. It shows the selected word as it was before that edge, and it holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_pulse_i | input | NUM_CH | Per-channel completion cause pulses |
| err_pulse_i | input | NUM_CH | Per-channel fault cause pulses |
| glb_pulse_i | input | GLB_W | Global event pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_kind_i | input | 3 | Register kind: 0 status, 1 mask, 2 outbound summary, 3 inbound summary, 4 global |
| reg_ch_i | input | CH_W | Channel select |
| reg_out_i | input | OUT_W | Interrupt line select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_OUT | Registered interrupt lines |

## Verification
A pulse sampled on edge k is visible in the status registers after edge k. A read request sampled on edge k+1 returns it after edge k+1, and the interrupt line changes after edge k+1 as well. The bench therefore computes each cycle's expected line values and read data from its model before the edge, and compares them just after that edge. Only then does it fold that cycle's pulses and writes into the model. Same-cycle set-and-clear and read-during-write are covered by this same ordering.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int REG_W         = 32;
  localparam int CAUSE_DONE_B  = 0;
  localparam int CAUSE_ERR_B   = 6;

  typedef enum logic [2:0] {
    RK_CH_STATUS  = 3'd0,
    RK_CH_MASK    = 3'd1,
    RK_TX_SUMMARY = 3'd2,
    RK_RX_SUMMARY = 3'd3,
    RK_GLOBAL     = 3'd4
  } reg_kind_e;

  function automatic logic [REG_W-1:0] pack_cause(input logic done_b, input logic err_b);
    logic [REG_W-1:0] w;
    w = '0;
    w[CAUSE_DONE_B] = done_b;
    w[CAUSE_ERR_B]  = err_b;
    return w;
  endfunction

endpackage

// File: rtl/irqagg_chan_cell.sv
module irqagg_chan_cell #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               done_pulse,
  input  logic               err_pulse,
  input  logic [NUM_OUT-1:0] clr_sel,
  input  logic [NUM_OUT-1:0] mask_sel,
  input  logic               wr_done,
  input  logic               wr_err,
  output logic [NUM_OUT-1:0] st_done,
  output logic [NUM_OUT-1:0] st_err,
  output logic [NUM_OUT-1:0] mk_done,
  output logic [NUM_OUT-1:0] mk_err,
  output logic [NUM_OUT-1:0] hit
);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_done <= '0;
      st_err  <= '0;
      mk_done <= '0;
      mk_err  <= '0;
    end else begin
      for (int o = 0; o < NUM_OUT; o++) begin
        // a fresh cause wins over a clear in the same cycle
        st_done[o] <= (st_done[o] & ~(clr_sel[o] & wr_done)) | done_pulse;
        st_err[o]  <= (st_err[o]  & ~(clr_sel[o] & wr_err))  | err_pulse;
        if (mask_sel[o]) begin
          mk_done[o] <= wr_done;
          mk_err[o]  <= wr_err;
        end
      end
    end
  end

  assign hit = (st_done & mk_done) | (st_err & mk_err);

endmodule

// File: rtl/irqagg_global.sv
module irqagg_global #(
  parameter int NUM_OUT = 4,
  parameter int GLB_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [GLB_W-1:0]              glb_pulse,
  input  logic [NUM_OUT-1:0]            clr_sel,
  input  logic [GLB_W-1:0]              clr_data,
  output logic [NUM_OUT-1:0][GLB_W-1:0] glb_st
);

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_st <= '0;
    end else begin
      for (int o = 0; o < NUM_OUT; o++) begin
        glb_st[o] <= (glb_st[o] & ~(clr_sel[o] ? clr_data : '0)) | glb_pulse;
      end
    end
  end

endmodule

// File: rtl/irqagg_summary.sv
module irqagg_summary #(
  parameter int NUM_CH  = 64,
  parameter int NUM_OUT = 4,
  parameter int GLB_W   = 8,
  localparam int PAIRS  = NUM_CH / 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_OUT-1:0][NUM_CH-1:0] hit,
  input  logic [NUM_OUT-1:0][GLB_W-1:0]  glb_st,
  output logic [NUM_OUT-1:0][PAIRS-1:0]  tx_sum,
  output logic [NUM_OUT-1:0][PAIRS-1:0]  rx_sum,
  output logic [NUM_OUT-1:0]             irq_q
);

  logic [NUM_OUT-1:0] line_next;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_line
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign tx_sum[o][p] = hit[o][2*p];
      assign rx_sum[o][p] = hit[o][2*p+1];
    end
    assign line_next[o] = (|tx_sum[o]) | (|rx_sum[o]) | (|glb_st[o]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= line_next;
  end

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int  NUM_CH  = 64,
  parameter int  NUM_OUT = 4,
  parameter int  GLB_W   = 8,
  localparam int CH_W    = (NUM_CH  > 1) ? $clog2(NUM_CH)  : 1,
  localparam int OUT_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int PAIRS   = NUM_CH / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CH-1:0]  done_pulse_i,
  input  logic [NUM_CH-1:0]  err_pulse_i,
  input  logic [GLB_W-1:0]   glb_pulse_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [2:0]         reg_kind_i,
  input  logic [CH_W-1:0]    reg_ch_i,
  input  logic [OUT_W-1:0]   reg_out_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic [NUM_OUT-1:0] irq_o
);

  reg_kind_e          kind;
  logic               ch_ok, out_ok;
  logic               clr_hit, mask_hit, glb_hit;
  logic [NUM_OUT-1:0] out_onehot;

  logic [NUM_CH-1:0][NUM_OUT-1:0] c_st_done, c_st_err, c_mk_done, c_mk_err, c_hit;
  logic [NUM_OUT-1:0][NUM_CH-1:0] done_st, err_st, done_mk, err_mk, hit;
  logic [NUM_OUT-1:0][GLB_W-1:0]  glb_st;
  logic [NUM_OUT-1:0][PAIRS-1:0]  tx_sum, rx_sum;
  logic [REG_W-1:0]               rd_next;

  assign kind       = reg_kind_e'(reg_kind_i);
  assign ch_ok      = (int'(reg_ch_i)  < NUM_CH);
  assign out_ok     = (int'(reg_out_i) < NUM_OUT);
  assign out_onehot = NUM_OUT'(1) << reg_out_i;
  assign clr_hit    = reg_we_i && (kind == RK_CH_STATUS) && ch_ok && out_ok;
  assign mask_hit   = reg_we_i && (kind == RK_CH_MASK)   && ch_ok && out_ok;
  assign glb_hit    = reg_we_i && (kind == RK_GLOBAL)    && out_ok;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_ch;
    assign sel_ch = (reg_ch_i == CH_W'(c));

    irqagg_chan_cell #(.NUM_OUT(NUM_OUT)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .done_pulse (done_pulse_i[c]),
      .err_pulse  (err_pulse_i[c]),
      .clr_sel    ((clr_hit  && sel_ch) ? out_onehot : '0),
      .mask_sel   ((mask_hit && sel_ch) ? out_onehot : '0),
      .wr_done    (reg_wdata_i[CAUSE_DONE_B]),
      .wr_err     (reg_wdata_i[CAUSE_ERR_B]),
      .st_done    (c_st_done[c]),
      .st_err     (c_st_err[c]),
      .mk_done    (c_mk_done[c]),
      .mk_err     (c_mk_err[c]),
      .hit        (c_hit[c])
    );

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_tr
      assign done_st[o][c] = c_st_done[c][o];
      assign err_st[o][c]  = c_st_err[c][o];
      assign done_mk[o][c] = c_mk_done[c][o];
      assign err_mk[o][c]  = c_mk_err[c][o];
      assign hit[o][c]     = c_hit[c][o];
    end
  end

  irqagg_global #(.NUM_OUT(NUM_OUT), .GLB_W(GLB_W)) u_global (
    .clk       (clk),
    .rst       (rst),
    .glb_pulse (glb_pulse_i),
    .clr_sel   (glb_hit ? out_onehot : '0),
    .clr_data  (reg_wdata_i[GLB_W-1:0]),
    .glb_st    (glb_st)
  );

  irqagg_summary #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT), .GLB_W(GLB_W)) u_summary (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .glb_st (glb_st),
    .tx_sum (tx_sum),
    .rx_sum (rx_sum),
    .irq_q  (irq_o)
  );

  always_comb begin
    rd_next = '0;
    if (out_ok) begin
      case (kind)
        RK_CH_STATUS:  if (ch_ok) rd_next = pack_cause(done_st[reg_out_i][reg_ch_i],
                                                       err_st[reg_out_i][reg_ch_i]);
        RK_CH_MASK:    if (ch_ok) rd_next = pack_cause(done_mk[reg_out_i][reg_ch_i],
                                                       err_mk[reg_out_i][reg_ch_i]);
        RK_TX_SUMMARY: rd_next[PAIRS-1:0] = tx_sum[reg_out_i];
        RK_RX_SUMMARY: rd_next[PAIRS-1:0] = rx_sum[reg_out_i];
        RK_GLOBAL:     rd_next[GLB_W-1:0] = glb_st[reg_out_i];
        default:       rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           reg_rdata_o <= '0;
    else if (reg_re_i) reg_rdata_o <= rd_next;
  end

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int  NUM_CH  = 64,
  parameter int  NUM_OUT = 4,
  parameter int  GLB_W   = 8,
  localparam int PAIRS   = NUM_CH / 2
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NUM_CH-1:0]              done_i,
  input logic [NUM_CH-1:0]              err_i,
  input logic                           reg_re,
  input logic [31:0]                    reg_rdata,
  input logic [NUM_OUT-1:0]             irq,
  input logic [NUM_OUT-1:0][NUM_CH-1:0] st_done,
  input logic [NUM_OUT-1:0][NUM_CH-1:0] st_err,
  input logic [NUM_OUT-1:0][PAIRS-1:0]  tx_sum,
  input logic [NUM_OUT-1:0][PAIRS-1:0]  rx_sum,
  input logic [NUM_OUT-1:0][GLB_W-1:0]  glb_st
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq == '0 && reg_rdata == '0));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    !reg_re |=> $stable(reg_rdata));

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    a_r2_done_lands: assert property (@(posedge clk) disable iff (rst || !armed)
      ((st_done[o] & $past(done_i)) == $past(done_i)));

    a_r2_err_lands: assert property (@(posedge clk) disable iff (rst || !armed)
      ((st_err[o] & $past(err_i)) == $past(err_i)));

    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (rst || !armed)
      ((st_done[o] & ~$past(st_done[o]) & ~$past(done_i)) == '0));

    a_r8_line_follows: assert property (@(posedge clk) disable iff (rst || !armed)
      irq[o] == $past((|tx_sum[o]) || (|rx_sum[o]) || (|glb_st[o])));
  end

endmodule

bind dma_irq_aggregator irqagg_checker #(
  .NUM_CH (NUM_CH),
  .NUM_OUT(NUM_OUT),
  .GLB_W  (GLB_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done_i    (done_pulse_i),
  .err_i     (err_pulse_i),
  .reg_re    (reg_re_i),
  .reg_rdata (reg_rdata_o),
  .irq       (irq_o),
  .st_done   (done_st),
  .st_err    (err_st),
  .tx_sum    (tx_sum),
  .rx_sum    (rx_sum),
  .glb_st    (glb_st)
);

// File: tb/dma_irq_aggregator_tb.sv
`timescale 1ns/1ps
module dma_irq_aggregator_tb;

  localparam int NUM_CH  = 64;
  localparam int NUM_OUT = 4;
  localparam int GLB_W   = 8;
  localparam int CH_W    = 6;
  localparam int OUT_W   = 2;
  localparam int PAIRS   = NUM_CH / 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_CH-1:0]  done_v = '0;
  logic [NUM_CH-1:0]  err_v = '0;
  logic [GLB_W-1:0]   glb_v = '0;
  logic               reg_we = 1'b0;
  logic               reg_re = 1'b0;
  logic [2:0]         reg_kind = '0;
  logic [CH_W-1:0]    reg_ch = '0;
  logic [OUT_W-1:0]   reg_out = '0;
  logic [31:0]        reg_wdata = '0;
  logic [31:0]        rdata;
  logic [NUM_OUT-1:0] irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [NUM_OUT-1:0][NUM_CH-1:0] md, me, mmd, mme;
  logic [NUM_OUT-1:0][GLB_W-1:0]  mg;

  always #10 clk = ~clk;

  dma_irq_aggregator #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT), .GLB_W(GLB_W)) u_dut (
    .clk (clk), .rst (rst),
    .done_pulse_i (done_v), .err_pulse_i (err_v), .glb_pulse_i (glb_v),
    .reg_we_i (reg_we), .reg_re_i (reg_re), .reg_kind_i (reg_kind),
    .reg_ch_i (reg_ch), .reg_out_i (reg_out), .reg_wdata_i (reg_wdata),
    .reg_rdata_o (rdata), .irq_o (irq)
  );

  function automatic logic [31:0] model_read(input logic [2:0] k, input int ch, input int o);
    logic [31:0] r;
    r = '0;
    case (k)
      3'd0: begin r[0] = md[o][ch];  r[6] = me[o][ch];  end
      3'd1: begin r[0] = mmd[o][ch]; r[6] = mme[o][ch]; end
      3'd2: for (int p = 0; p < PAIRS; p++)
              r[p] = (md[o][2*p] & mmd[o][2*p]) | (me[o][2*p] & mme[o][2*p]);
      3'd3: for (int p = 0; p < PAIRS; p++)
              r[p] = (md[o][2*p+1] & mmd[o][2*p+1]) | (me[o][2*p+1] & mme[o][2*p+1]);
      3'd4: r[GLB_W-1:0] = mg[o];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [NUM_OUT-1:0] model_irq();
    logic [NUM_OUT-1:0] v;
    for (int o = 0; o < NUM_OUT; o++)
      v[o] = (|((md[o] & mmd[o]) | (me[o] & mme[o]))) | (|mg[o]);
    return v;
  endfunction

  function automatic string kind_tag(input logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R5";
      3'd2, 3'd3: return "R6";
      3'd4: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic model_update();
    for (int o = 0; o < NUM_OUT; o++) begin
      if (reg_we && reg_kind == 3'd0 && int'(reg_out) == o) begin
        if (reg_wdata[0]) md[o][reg_ch] = 1'b0;
        if (reg_wdata[6]) me[o][reg_ch] = 1'b0;
      end
      if (reg_we && reg_kind == 3'd1 && int'(reg_out) == o) begin
        mmd[o][reg_ch] = reg_wdata[0];
        mme[o][reg_ch] = reg_wdata[6];
      end
      if (reg_we && reg_kind == 3'd4 && int'(reg_out) == o)
        mg[o] = mg[o] & ~reg_wdata[GLB_W-1:0];
      md[o] = md[o] | done_v;
      me[o] = me[o] | err_v;
      mg[o] = mg[o] | glb_v;
    end
  endtask

  // inputs are set after a falling edge; expectations come from the model before the edge
  task automatic step(input string tag);
    logic [NUM_OUT-1:0] ei;
    logic [31:0]        er;
    logic               do_rd;
    string              t;
    ei    = model_irq();
    er    = model_read(reg_kind, int'(reg_ch), int'(reg_out));
    do_rd = reg_re;
    t     = (tag == "") ? kind_tag(reg_kind) : tag;
    @(posedge clk);
    #1;
    check("R8", 32'(irq), 32'(ei));
    if (do_rd) check(t, rdata, er);
    model_update();
    @(negedge clk);
    done_v = '0; err_v = '0; glb_v = '0;
    reg_we = 1'b0; reg_re = 1'b0; reg_wdata = '0;
  endtask

  task automatic wr(input logic [2:0] k, input int ch, input int o, input logic [31:0] d);
    reg_we = 1'b1; reg_kind = k; reg_ch = CH_W'(ch); reg_out = OUT_W'(o); reg_wdata = d;
  endtask

  task automatic rd(input logic [2:0] k, input int ch, input int o);
    reg_re = 1'b1; reg_kind = k; reg_ch = CH_W'(ch); reg_out = OUT_W'(o);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    md = '0; me = '0; mmd = '0; mme = '0; mg = '0;
    void'($urandom(32'd7351));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", 32'(irq), 32'd0);
    check("R1", rdata, 32'd0);
    rd(3'd0, 0, 0);  step("R1");
    rd(3'd1, 63, 3); step("R1");
    rd(3'd2, 0, 3);  step("R1");
    rd(3'd4, 0, 0);  step("R1");

    // R2: causes land in every line's copy
    done_v[5] = 1'b1; step("R2");
    rd(3'd0, 5, 2);   step("R2");
    err_v[10] = 1'b1; step("R2");
    rd(3'd0, 10, 0);  step("R2");

    // R5: mask load, only bits 0 and 6 stored
    wr(3'd1, 5, 1, 32'h41);         step("R5");
    rd(3'd1, 5, 1);                 step("R5");
    wr(3'd1, 7, 0, 32'hFFFF_FFFF);  step("R5");
    rd(3'd1, 7, 0);                 step("R5");

    // R6: odd channel 5 lands in inbound bit 2; even channel 10 in outbound bit 5
    rd(3'd3, 0, 1);              step("R6");
    wr(3'd1, 10, 1, 32'h40);     step("R6");
    rd(3'd2, 0, 1);              step("R6");

    // R4: clear and new cause in one cycle keep the bit
    wr(3'd0, 5, 1, 32'h1); done_v[5] = 1'b1; step("R4");
    rd(3'd0, 5, 1);                         step("R4");

    // R3: clear acts on one copy only; zero data clears nothing
    wr(3'd0, 5, 1, 32'h1);  step("R3");
    rd(3'd0, 5, 1);         step("R3");
    rd(3'd0, 5, 0);         step("R3");
    wr(3'd0, 10, 0, 32'h0); step("R3");
    rd(3'd0, 10, 0);        step("R3");

    // R8: removing the fault enable of channel 10 drops line 1
    wr(3'd1, 10, 1, 32'h0); step("R8");
    step("R8");
    check("R8", 32'(irq[1]), 32'd0);

    // R9: writes to summary and unused kinds change nothing
    wr(3'd2, 0, 1, 32'hFFFF_FFFF); step("R9");
    wr(3'd3, 5, 1, 32'hFFFF_FFFF); step("R9");
    wr(3'd6, 10, 0, 32'hFFFF_FFFF); step("R9");
    rd(3'd0, 10, 0);  step("R9");
    rd(3'd1, 7, 0);   step("R9");
    rd(3'd0, 5, 0);   step("R9");

    // R7: global causes, write-ones clear, set wins
    glb_v = 8'h81;                      step("R7");
    rd(3'd4, 0, 3);                     step("R7");
    wr(3'd4, 0, 3, 32'h01);             step("R7");
    rd(3'd4, 0, 3);                     step("R7");
    wr(3'd4, 0, 0, 32'hFF); glb_v = 8'h01; step("R4");
    rd(3'd4, 0, 0);                     step("R7");

    // R10: read data holds when no read is issued
    rd(3'd4, 0, 3); step("R10");
    held = rdata;
    wr(3'd4, 0, 3, 32'hFF); step("R10");
    check("R10", rdata, held);

    for (int n = 0; n < 3000; n++) begin
      done_v = NUM_CH'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      err_v  = NUM_CH'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                       & {$urandom, $urandom});
      glb_v  = GLB_W'($urandom & $urandom & $urandom & $urandom);
      reg_kind  = 3'($urandom_range(0, 5));
      reg_ch    = CH_W'($urandom);
      reg_out   = OUT_W'($urandom);
      reg_we    = ($urandom % 3 == 0);
      reg_re    = ($urandom % 2 == 0);
      reg_wdata = $urandom;
      step("");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule